// File: doc/BRIEF.md
# Quadrant-Selectable Memory Parity Checker

This block sits beside a memory port with a 16-bit address space and guards its data words with one parity bit each. The space is divided into four equal quadrants of 16K words, and software turns parity on or off for each quadrant separately. Software also chooses, at run time, whether the stored bit follows odd or even parity.

On a write into an enabled quadrant the block produces, in the same cycle, the parity bit that memory should store alongside the word. On a read from an enabled quadrant it rebuilds parity from the returned data and compares the result with the returned parity bit. A mismatch gives a one-cycle error pulse. The first failing address is held in a capture register until software clears it, so later failures cannot hide where the trouble began.

Configuration arrives through a single write port that loads the four quadrant enables and the polarity select together.

Top module: `qpar_guard`

## Requirements
- R1: After reset all four quadrant enables are 0, even parity is selected, `fail_flag` is 0, `fail_addr` is 0 and `err_pulse` is 0. A write anywhere then gives `par_out` = 0.
- R2: The quadrant is `mem_addr[15:14]`. Quadrant k (0: 0000-3FFF, 1: 4000-7FFF, 2: 8000-BFFF, 3: C000-FFFF) is enabled by `cfg_wdata[k]`.
- R3: During a write strobe (`mem_valid`=1, `mem_write`=1) to an enabled quadrant, `par_out` is combinationally the XOR of all bits of `mem_data` when `cfg_wdata[4]` was written 0 (even parity). It is the inverse of that XOR when `cfg_wdata[4]` was written 1 (odd parity).
- R4: `par_out` is 0 during a write to a disabled quadrant and in every cycle that is not a write strobe.
- R5: A read strobe (`mem_valid`=1, `mem_write`=0) to an enabled quadrant whose `mem_par_in` differs from the parity that R3 would generate for `mem_data` raises `err_pulse` for exactly the following cycle.
- R6: A read to a disabled quadrant, and a read whose parity matches, raise no `err_pulse`.
- R7: On an error while `fail_flag` is 0, the cycle after the failing read shows `fail_flag` = 1 and `fail_addr` equal to that read's address.
- R8: While `fail_flag` is 1, later errors still pulse `err_pulse` but leave `fail_addr` unchanged.
- R9: A `clr_fail` strobe makes `fail_flag` and `fail_addr` 0 in the next cycle. This holds even if an error occurs in the same cycle, and that error is not captured.
- R10: A configuration write (`cfg_we`=1) takes effect from the next cycle. A transfer in the same cycle as the write uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load configuration |
| cfg_wdata | input | 5 | [3:0] quadrant enables, [4] odd parity select |
| clr_fail | input | 1 | Clear the captured failure |
| mem_valid | input | 1 | Memory transfer strobe |
| mem_write | input | 1 | 1 = write, 0 = read |
| mem_addr | input | 16 | Transfer address |
| mem_data | input | 16 | Data word of the transfer |
| mem_par_in | input | 1 | Parity bit returned with read data |
| par_out | output | 1 | Generated parity bit for a write |
| err_pulse | output | 1 | One-cycle parity error indication |
| fail_flag | output | 1 | A failure has been captured |
| fail_addr | output | 16 | Address of the first captured failure |

## Verification
The bench hits the address edges of each quadrant, such as 3FFF/4000 and BFFF/C000. A design that decoded the wrong address bits would check or skip the wrong region. All-zero and all-one data words are used under both polarities. An inverted polarity select would then either flag every good read or generate wrong stored bits. A second failure is sent while one is already held, and a clear is issued in the same cycle as a fresh error. A capture register that is not frozen would move, and one where the clear does not win would come back nonzero. A configuration write is made in the same cycle as a read, which exposes a design that lets new enables act one cycle early.

// File: rtl/qpar_guard.sv
module qpar_guard #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int QUADS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [QUADS:0]    cfg_wdata,
  input  logic              clr_fail,
  input  logic              mem_valid,
  input  logic              mem_write,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              mem_par_in,
  output logic              par_out,
  output logic              err_pulse,
  output logic              fail_flag,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int QSEL_W = $clog2(QUADS);

  logic [QUADS-1:0]  quad_en;
  logic              odd_sel;
  logic [QSEL_W-1:0] quad;
  logic              hit_en;
  logic              gen_bit;
  logic              mismatch;

  assign quad     = mem_addr[ADDR_W-1 -: QSEL_W];
  assign hit_en   = quad_en[quad];
  assign gen_bit  = (^mem_data) ^ odd_sel;
  assign par_out  = mem_valid & mem_write & hit_en & gen_bit;
  assign mismatch = mem_valid & ~mem_write & hit_en & (gen_bit ^ mem_par_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quad_en   <= '0;
      odd_sel   <= 1'b0;
      err_pulse <= 1'b0;
      fail_flag <= 1'b0;
      fail_addr <= '0;
    end else begin
      if (cfg_we) begin
        quad_en <= cfg_wdata[QUADS-1:0];
        odd_sel <= cfg_wdata[QUADS];
      end
      err_pulse <= mismatch;
      if (clr_fail) begin
        fail_flag <= 1'b0;
        fail_addr <= '0;
      end else if (mismatch && !fail_flag) begin
        fail_flag <= 1'b1;
        fail_addr <= mem_addr;
      end
    end
  end
endmodule

// File: rtl/qpar_guard_chk.sv
module qpar_guard_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_fail,
  input logic              mem_valid,
  input logic              mem_write,
  input logic              par_out,
  input logic              err_pulse,
  input logic              fail_flag,
  input logic [ADDR_W-1:0] fail_addr
);
  p_par_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && mem_write) |-> !par_out);

  p_err_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(mem_valid && !mem_write));

  p_err_captured_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && !$past(clr_fail)) |-> fail_flag);

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !clr_fail) |=> (fail_flag && $stable(fail_addr)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fail |=> (!fail_flag && fail_addr == '0));
endmodule

bind qpar_guard qpar_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_qpar_guard.sv
module tb_qpar_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_wdata = '0;
  logic        clr_fail = 1'b0;
  logic        mem_valid = 1'b0;
  logic        mem_write = 1'b0;
  logic [15:0] mem_addr = '0;
  logic [15:0] mem_data = '0;
  logic        mem_par_in = 1'b0;
  logic        par_out, err_pulse, fail_flag;
  logic [15:0] fail_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  qpar_guard dut (.*);

  // {cfg[4:0], wr, addr, data, par_in, exp_par, exp_err}
  localparam logic [40:0] VEC [12] = '{
    {5'b00001, 1'b1, 16'h0010, 16'h0001, 1'b0, 1'b1, 1'b0},
    {5'b00001, 1'b1, 16'h4010, 16'h0001, 1'b0, 1'b0, 1'b0},
    {5'b10001, 1'b1, 16'h0020, 16'h0003, 1'b0, 1'b1, 1'b0},
    {5'b01000, 1'b0, 16'hC000, 16'h0007, 1'b0, 1'b0, 1'b1},
    {5'b01000, 1'b0, 16'hC004, 16'h0007, 1'b1, 1'b0, 1'b0},
    {5'b00100, 1'b0, 16'h8000, 16'hFFFF, 1'b1, 1'b0, 1'b1},
    {5'b00100, 1'b0, 16'h7FFF, 16'hFFFF, 1'b1, 1'b0, 1'b0},
    {5'b11111, 1'b0, 16'h4000, 16'h0000, 1'b0, 1'b0, 1'b1},
    {5'b11111, 1'b0, 16'hBFFF, 16'h00FF, 1'b1, 1'b0, 1'b0},
    {5'b00010, 1'b1, 16'h7FFF, 16'h8000, 1'b0, 1'b1, 1'b0},
    {5'b00000, 1'b0, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b0},
    {5'b10010, 1'b1, 16'h4000, 16'hFFFF, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [4:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_xact(input logic w, input logic [15:0] a, input logic [15:0] d, input logic p);
    mem_valid = 1'b1; mem_write = w; mem_addr = a; mem_data = d; mem_par_in = p;
    #1;
  endtask

  task automatic end_xact();
    @(negedge clk);
    mem_valid = 1'b0; mem_write = 1'b0;
  endtask

  task automatic pulse_clear();
    clr_fail = 1'b1;
    @(negedge clk);
    clr_fail = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 fail_flag", {15'd0, fail_flag}, 16'd0);
    chk("R1 fail_addr", fail_addr, 16'h0000);
    chk("R1 err_pulse", {15'd0, err_pulse}, 16'd0);
    start_xact(1'b1, 16'h0000, 16'h0001, 1'b0);
    chk("R1 par_out all disabled", {15'd0, par_out}, 16'd0);
    end_xact();

    for (int i = 0; i < 12; i++) begin
      logic [40:0] v;
      v = VEC[i];
      set_cfg(v[40:36]);
      @(negedge clk);
      start_xact(v[35], v[34:19], v[18:3], v[2]);
      chk($sformatf("R2 R3 R4 vec %0d par_out", i), {15'd0, par_out}, {15'd0, v[1]});
      end_xact();
      chk($sformatf("R5 R6 vec %0d err_pulse", i), {15'd0, err_pulse}, {15'd0, v[0]});
      pulse_clear();
    end

    set_cfg(5'b00001);
    @(negedge clk);
    start_xact(1'b0, 16'h1234, 16'h0001, 1'b0);
    end_xact();
    chk("R5 err_pulse", {15'd0, err_pulse}, 16'd1);
    chk("R7 fail_flag", {15'd0, fail_flag}, 16'd1);
    chk("R7 fail_addr", fail_addr, 16'h1234);
    @(negedge clk);
    chk("R5 single cycle pulse", {15'd0, err_pulse}, 16'd0);
    start_xact(1'b0, 16'h2222, 16'h0001, 1'b0);
    end_xact();
    chk("R8 second err pulses", {15'd0, err_pulse}, 16'd1);
    chk("R8 addr frozen", fail_addr, 16'h1234);

    start_xact(1'b0, 16'h3333, 16'h0001, 1'b0);
    clr_fail = 1'b1;
    end_xact();
    clr_fail = 1'b0;
    chk("R9 clear wins flag", {15'd0, fail_flag}, 16'd0);
    chk("R9 clear wins addr", fail_addr, 16'h0000);
    chk("R9 err still pulses", {15'd0, err_pulse}, 16'd1);
    start_xact(1'b0, 16'h0ABC, 16'h0001, 1'b0);
    end_xact();
    chk("R7 capture after clear", fail_addr, 16'h0ABC);
    pulse_clear();

    cfg_we = 1'b1; cfg_wdata = 5'b00010;
    start_xact(1'b0, 16'h4000, 16'h0001, 1'b0);
    end_xact();
    cfg_we = 1'b0;
    chk("R10 old cfg in write cycle", {15'd0, err_pulse}, 16'd0);
    start_xact(1'b0, 16'h4000, 16'h0001, 1'b0);
    end_xact();
    chk("R10 new cfg next cycle", {15'd0, err_pulse}, 16'd1);
    start_xact(1'b0, 16'h0000, 16'h0001, 1'b0);
    end_xact();
    chk("R2 quadrant 0 now disabled", {15'd0, err_pulse}, 16'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule